// File: doc/BRIEF.md
# Scan Test Sequencer

This block drives combinational test patterns into a design whose flops are wired as mux-D scan chains, and checks the results. One shared test-control line selects between shifting (0) and functional capture (1). Each chain has its own serial input and output. For every pattern the sequencer shifts in the state bits, holds test-control high for exactly one clock so the flops capture their next state, and then shifts that captured response out while the next pattern's state bits shift in. The outgoing bits are compared against expected data, and any difference is recorded.

Patterns come from an external store through a synchronous read port. A word holds the per-chain stimulus, the primary-input value, the expected captured state and the expected primary-output value. Chains may differ in length. Every shift phase lasts as long as the longest chain, and each shorter chain receives filler bits at the front of its stream. A pulse on `start` runs the number of patterns given on `numVec`. `busy` stays high for the whole run, and `done` pulses once at the end. A sticky mismatch flag and a saturating count of failing compare cycles stay valid until the next start.

Top module: `scanTestSeq`

## Requirements
- R1: `testCtrl` is 0 while idle and during shifting. In a run it goes to 1 for exactly one cycle after each run of MAX_LEN consecutive shift cycles, except after the final unload phase.
- R2: In shift cycle j (0 = first) of a loading phase, chain c receives bit MAX_LEN-1-j of its MAX_LEN-bit stimulus field, which is `memStim[c*MAX_LEN +: MAX_LEN]`. When capture begins, cell i of a chain of length L holds field bit i for i < L. Field bits L and above are filler and have no effect on the loaded state or on the compare result.
- R3: In shift cycle j of phase p > 0, `scanOut[c]` is compared with bit L-1-j of chain c's field in the expected-response word of pattern p-1, for j < L only. Expected-field bits at position L and above are never compared.
- R4: With N patterns and a longest chain of MAX_LEN flops, `busy` is high for exactly (N+1)·MAX_LEN + N cycles, starting in the cycle after `start` is taken.
- R5: No compare is made during the first shift phase of a run, so whatever the chains hold before the run cannot raise a mismatch.
- R6: During the final unload phase, every `scanIn` bit is 0.
- R7: In the capture cycle of pattern k, `piOut` carries that pattern's primary-input value, and `poIn` is compared with its expected primary-output value.
- R8: A compare cycle with one or more differing bits sets the sticky `mismatch` and adds one to `mismatchCnt`. Both are cleared when a new run starts.
- R9: `done` is high for exactly one cycle: the first cycle in which `busy` is low after a run.
- R10: `start` has no effect while `busy` is high.
- R11: The store is read at address 0 in the cycle that `start` is taken (when N > 0), and at address k+1 in the capture cycle of pattern k (when k+1 < N). There are no other reads, and the read data is used from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| numVec | input | VEC_AW+1 | Number of patterns in the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| memRdEn | output | 1 | Pattern store read enable |
| memAddr | output | VEC_AW | Pattern store address |
| memStim | input | NUM_CHAINS*MAX_LEN | Stimulus fields, one per chain |
| memPi | input | PI_W | Primary-input value of the pattern |
| memExpResp | input | NUM_CHAINS*MAX_LEN | Expected captured state, one field per chain |
| memExpPo | input | PO_W | Expected primary-output value |
| testCtrl | output | 1 | Shared test control: 0 shift, 1 capture |
| scanIn | output | NUM_CHAINS | Serial data into each chain |
| scanOut | input | NUM_CHAINS | Serial data from the last cell of each chain |
| piOut | output | PI_W | Primary inputs applied to the design |
| poIn | input | PO_W | Primary outputs of the design |
| mismatch | output | 1 | Sticky compare-failure flag |
| mismatchCnt | output | CNT_W | Count of failing compare cycles (saturating) |

## Verification
A bit counter that slips shows up as a wrong busy length. It also shows up as a capture that comes at the wrong shift count, which the bench sees at the first `testCtrl` pulse, MAX_LEN cycles into the run. A reversed or misaligned bit index corrupts the state loaded into the bench's own chain model, which is checked in every capture cycle. It also produces false mismatches one phase later, during the unload. A lost expected-response latch or a wrong compare window appears in the final `mismatch` and `mismatchCnt` as soon as the run ends. Faults planted in selected response bits and in filler bits tell a correct window apart from a wrong one.

// File: rtl/scanSeqPkg.sv
package scanSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // run accepted: reset result state
    logic shift;    // scan shift cycle
    logic unload;   // shift cycle of the final (vector-less) phase
    logic cmpScan;  // shifted-out bits carry a valid response
    logic capture;  // functional capture cycle
  } seqStrobe_t;

endpackage

// File: rtl/scanSeqCtrl.sv
module scanSeqCtrl
  import scanSeqPkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int VEC_AW  = 2,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VEC_AW:0]   numVec,
  output logic              busy,
  output logic              done,
  output logic              memRdEn,
  output logic [VEC_AW-1:0] memAddr,
  output logic              testCtrl,
  output seqStrobe_t        stb,
  output logic [IDX_W-1:0]  bitIdx
);

  seqState_e         state;
  logic [IDX_W-1:0]  bitCnt;
  logic [VEC_AW:0]   phase;
  logic [VEC_AW:0]   numVecR;
  logic              doneR;

  logic              lastBit;
  logic              lastPhase;
  logic              accept;
  logic [VEC_AW:0]   nextPhase;

  assign lastBit   = (bitCnt == IDX_W'(MAX_LEN - 1));
  assign lastPhase = (phase == numVecR);
  assign accept    = (state == ST_IDLE) && start;
  assign nextPhase = phase + (VEC_AW + 1)'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      phase   <= '0;
      numVecR <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            numVecR <= numVec;
            phase   <= '0;
            bitCnt  <= '0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (lastBit) begin
            bitCnt <= '0;
            if (lastPhase) begin
              state <= ST_IDLE;
              doneR <= 1'b1;
            end else begin
              state <= ST_CAPT;
            end
          end else begin
            bitCnt <= bitCnt + IDX_W'(1);
          end
        end
        ST_CAPT: begin
          phase <= nextPhase;
          state <= ST_SHIFT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read-ahead: vector 0 on accept, vector k+1 during capture of vector k
  always_comb begin
    memRdEn = 1'b0;
    memAddr = nextPhase[VEC_AW-1:0];
    if (accept) begin
      memRdEn = (numVec != '0);
      memAddr = '0;
    end else if (state == ST_CAPT) begin
      memRdEn = (nextPhase < numVecR);
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = doneR;
  assign testCtrl = (state == ST_CAPT);
  assign bitIdx   = bitCnt;

  always_comb begin
    stb         = '0;
    stb.clear   = accept;
    stb.shift   = (state == ST_SHIFT);
    stb.unload  = (state == ST_SHIFT) && lastPhase;
    stb.cmpScan = (state == ST_SHIFT) && (phase != '0);
    stb.capture = (state == ST_CAPT);
  end

  AST_CAPT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    testCtrl |=> !testCtrl); // R1
  AST_SHIFT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && !lastBit) |=> (state == ST_SHIFT && !testCtrl)); // R1
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (phase <= numVecR)); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (numVecR == $past(numVecR))); // R10
  AST_READ_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (state == ST_SHIFT && bitCnt == '0)); // R11

endmodule

// File: rtl/scanSeqData.sv
module scanSeqData
  import scanSeqPkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN [NUM_CHAINS] = '{8, 5},
  parameter int MAX_LEN    = 8,
  parameter int IDX_W      = 3,
  parameter int PI_W       = 4,
  parameter int PO_W       = 4,
  parameter int CNT_W      = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    stb,
  input  logic [IDX_W-1:0]              bitIdx,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] memStim,
  input  logic [PI_W-1:0]               memPi,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] memExpResp,
  input  logic [PO_W-1:0]               memExpPo,
  output logic [NUM_CHAINS-1:0]         scanIn,
  input  logic [NUM_CHAINS-1:0]         scanOut,
  output logic [PI_W-1:0]               piOut,
  input  logic [PO_W-1:0]               poIn,
  output logic                          mismatch,
  output logic [CNT_W-1:0]              mismatchCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CHAINS*MAX_LEN-1:0] expReg;
  logic [NUM_CHAINS-1:0]         chainBad;
  logic                          poBad;
  logic                          anyBad;
  logic [IDX_W-1:0]              inIdx;

  // first bit shifted travels furthest: MSB of the field leads
  assign inIdx = IDX_W'(MAX_LEN - 1) - bitIdx;

  for (genvar gc = 0; gc < NUM_CHAINS; gc++) begin : gChain
    localparam int LEN = CHAIN_LEN[gc];
    logic [MAX_LEN-1:0] stimF;
    logic [MAX_LEN-1:0] expF;
    logic [IDX_W-1:0]   outIdx;
    logic               inWindow;

    assign stimF    = memStim[gc*MAX_LEN +: MAX_LEN];
    assign expF     = expReg[gc*MAX_LEN +: MAX_LEN];
    assign outIdx   = IDX_W'(LEN - 1) - bitIdx;
    assign inWindow = ({1'b0, bitIdx} < (IDX_W + 1)'(LEN));

    assign scanIn[gc]   = stb.shift && !stb.unload && stimF[inIdx];
    assign chainBad[gc] = stb.cmpScan && inWindow && (scanOut[gc] != expF[outIdx]);
  end

  assign piOut  = memPi;
  assign poBad  = stb.capture && (poIn != memExpPo);
  assign anyBad = (|chainBad) || poBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg      <= '0;
      mismatch    <= 1'b0;
      mismatchCnt <= '0;
    end else begin
      if (stb.capture) expReg <= memExpResp;
      if (stb.clear) begin
        mismatch    <= 1'b0;
        mismatchCnt <= '0;
      end else if (anyBad) begin
        mismatch <= 1'b1;
        if (mismatchCnt != CNT_MAX) mismatchCnt <= mismatchCnt + CNT_W'(1);
      end
    end
  end

  AST_NO_EARLY_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.cmpScan && !stb.capture && !stb.clear) |=> (mismatchCnt == $past(mismatchCnt))); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (mismatch && !stb.clear) |=> mismatch); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (!mismatch && mismatchCnt == '0)); // R8
  AST_UNLOAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stb.unload |-> (scanIn == '0)); // R6

endmodule

// File: rtl/scanTestSeq.sv
module scanTestSeq
  import scanSeqPkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN [NUM_CHAINS] = '{8, 5},
  parameter int PI_W       = 4,
  parameter int PO_W       = 4,
  parameter int VEC_AW     = 2,
  parameter int CNT_W      = 8,
  parameter int MAX_LEN    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [VEC_AW:0]               numVec,
  output logic                          busy,
  output logic                          done,
  output logic                          memRdEn,
  output logic [VEC_AW-1:0]             memAddr,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] memStim,
  input  logic [PI_W-1:0]               memPi,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] memExpResp,
  input  logic [PO_W-1:0]               memExpPo,
  output logic                          testCtrl,
  output logic [NUM_CHAINS-1:0]         scanIn,
  input  logic [NUM_CHAINS-1:0]         scanOut,
  output logic [PI_W-1:0]               piOut,
  input  logic [PO_W-1:0]               poIn,
  output logic                          mismatch,
  output logic [CNT_W-1:0]              mismatchCnt
);

  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  function automatic int longestChain();
    int m = 1;
    for (int i = 0; i < NUM_CHAINS; i++) if (CHAIN_LEN[i] > m) m = CHAIN_LEN[i];
    return m;
  endfunction

  localparam int LONGEST = longestChain();

  // shift length must equal the longest chain
  initial begin
    AST_LEN_CFG: assert (LONGEST == MAX_LEN); // R4
  end

  seqStrobe_t       stb;
  logic [IDX_W-1:0] bitIdx;

  scanSeqCtrl #(
    .MAX_LEN (MAX_LEN),
    .VEC_AW  (VEC_AW),
    .IDX_W   (IDX_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .numVec   (numVec),
    .busy     (busy),
    .done     (done),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .testCtrl (testCtrl),
    .stb      (stb),
    .bitIdx   (bitIdx)
  );

  scanSeqData #(
    .NUM_CHAINS (NUM_CHAINS),
    .CHAIN_LEN  (CHAIN_LEN),
    .MAX_LEN    (MAX_LEN),
    .IDX_W      (IDX_W),
    .PI_W       (PI_W),
    .PO_W       (PO_W),
    .CNT_W      (CNT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .bitIdx      (bitIdx),
    .memStim     (memStim),
    .memPi       (memPi),
    .memExpResp  (memExpResp),
    .memExpPo    (memExpPo),
    .scanIn      (scanIn),
    .scanOut     (scanOut),
    .piOut       (piOut),
    .poIn        (poIn),
    .mismatch    (mismatch),
    .mismatchCnt (mismatchCnt)
  );

endmodule

// File: tb/sim_scanTestSeq.sv
`timescale 1ns/1ps
module sim_scanTestSeq;

  localparam int L = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  numVec = '0;
  logic        busy, done, memRdEn, testCtrl, mismatch;
  logic [1:0]  memAddr;
  logic [15:0] memStim, memExpResp;
  logic [3:0]  memPi, memExpPo, piOut, poIn;
  logic [1:0]  scanIn, scanOut;
  logic [7:0]  mismatchCnt;

  always #4 clk = ~clk;

  scanTestSeq u0 (
    .clk(clk), .rstN(rstN), .start(start), .numVec(numVec),
    .busy(busy), .done(done), .memRdEn(memRdEn), .memAddr(memAddr),
    .memStim(memStim), .memPi(memPi), .memExpResp(memExpResp), .memExpPo(memExpPo),
    .testCtrl(testCtrl), .scanIn(scanIn), .scanOut(scanOut),
    .piOut(piOut), .poIn(poIn), .mismatch(mismatch), .mismatchCnt(mismatchCnt)
  );

  // pattern store
  logic [15:0] stimMem [4];
  logic [3:0]  piMem   [4];
  logic [15:0] erMem   [4];
  logic [3:0]  epMem   [4];

  always_ff @(posedge clk) begin
    if (memRdEn) begin
      memStim    <= stimMem[memAddr];
      memPi      <= piMem[memAddr];
      memExpResp <= erMem[memAddr];
      memExpPo   <= epMem[memAddr];
    end
  end

  // circuit under test: chain0 8 cells, chain1 5 cells
  logic [7:0] c0 = '0;
  logic [4:0] c1 = '0;
  logic       preload = 1'b0;

  function automatic logic [12:0] nsFn(input logic [12:0] s, input logic [3:0] p);
    return {s[11:0], s[12]} ^ {p, 5'b0, p} ^ {12'b0, ^s};
  endfunction
  function automatic logic [3:0] poFn(input logic [12:0] s, input logic [3:0] p);
    return s[3:0] ^ s[12:9] ^ {p[2:0], p[3]};
  endfunction

  always_ff @(posedge clk) begin
    if (preload) begin
      c0 <= '1; c1 <= '1;
    end else if (testCtrl) begin
      {c1, c0} <= nsFn({c1, c0}, piOut);
    end else begin
      c0 <= {c0[6:0], scanIn[0]};
      c1 <= {c1[3:0], scanIn[1]};
    end
  end
  assign scanOut = {c1[4], c0[7]};
  assign poIn    = poFn({c1, c0}, piOut);

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setVectors();
    for (int k = 0; k < 4; k++) begin
      logic [12:0] s, ns;
      stimMem[k] = 16'h5A3C ^ (16'(k) * 16'h2B71);
      piMem[k]   = 4'(3 * k + 1);
      s          = {stimMem[k][12:8], stimMem[k][7:0]};
      ns         = nsFn(s, piMem[k]);
      erMem[k]   = {3'b000, ns[12:8], ns[7:0]};
      epMem[k]   = poFn(s, piMem[k]);
    end
  endtask

  // runs one sequence from a negedge; checks framing, loading, PI, reads, done
  task automatic runSeq(input int n, input bit pokeStart);
    int busyCyc = 0, capIdx = 0, runLen = 0, rdCnt = 0, guard = 0;
    bit ok1 = 1, ok2 = 1, ok6 = 1, ok7 = 1, ok11 = 1;
    numVec = 3'(n);
    start  = 1'b1;
    #1;
    check(memRdEn == (n != 0) && memAddr == 2'd0, "R11", "read at start", memRdEn, n != 0);
    if (memRdEn) rdCnt++;
    @(negedge clk);
    start = 1'b0;
    while (busy && guard < 1000) begin
      guard++;
      busyCyc++;
      start = (pokeStart && busyCyc == 5);
      if (testCtrl) begin
        if (runLen != L) ok1 = 0;
        if ({c1, c0} != {stimMem[capIdx][12:8], stimMem[capIdx][7:0]}) ok2 = 0;
        if (piOut != piMem[capIdx]) ok7 = 0;
        if (memRdEn) begin
          if (int'(memAddr) != capIdx + 1 || capIdx + 1 >= n) ok11 = 0;
          rdCnt++;
        end
        capIdx++;
        runLen = 0;
      end else begin
        runLen++;
        if (memRdEn) ok11 = 0;
        if (capIdx == n && scanIn != 2'b00) ok6 = 0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(busyCyc == (n + 1) * L + n, "R4", "busy cycles", busyCyc, (n + 1) * L + n);
    check(ok1 && capIdx == n && runLen == L, "R1", "capture framing", capIdx, n);
    check(ok2, "R2", "loaded chain state at capture", ok2, 1);
    check(ok7, "R7", "piOut during capture", ok7, 1);
    check(ok6, "R6", "zero scanIn in unload", ok6, 1);
    check(ok11 && rdCnt == n, "R11", "read count/addresses", rdCnt, n);
    check(done == 1'b1, "R9", "done after busy", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", done, 0);
  endtask

  task automatic tReset();
    check(!busy && !done && !testCtrl && !mismatch && mismatchCnt == 0 && !memRdEn,
          "R1", "reset state", {busy, done, testCtrl, mismatch}, 0);
  endtask

  task automatic tClean();
    setVectors();
    runSeq(4, 0);
    check(!mismatch && mismatchCnt == 0, "R3", "clean run no mismatch", mismatchCnt, 0);
  endtask

  task automatic tFirstMasked();
    setVectors();
    @(negedge clk); preload = 1'b1;
    @(negedge clk); preload = 1'b0;
    runSeq(2, 0);
    check(mismatchCnt == 0, "R5", "first phase masked", mismatchCnt, 0);
  endtask

  task automatic tRespFault();
    setVectors();
    erMem[1][3] = ~erMem[1][3];
    runSeq(3, 0);
    check(mismatch && mismatchCnt == 1, "R3", "one response bit wrong", mismatchCnt, 1);
  endtask

  task automatic tBeyondWindow();
    setVectors();
    erMem[1][14] = ~erMem[1][14];
    erMem[2][13] = ~erMem[2][13];
    runSeq(3, 0);
    check(mismatchCnt == 0, "R3", "bits past chain end ignored", mismatchCnt, 0);
  endtask

  task automatic tPoFault();
    setVectors();
    epMem[2][1] = ~epMem[2][1];
    runSeq(3, 0);
    check(mismatch && mismatchCnt == 1, "R7", "PO mismatch", mismatchCnt, 1);
  endtask

  task automatic tPadIgnored();
    setVectors();
    for (int k = 0; k < 4; k++) stimMem[k][15:13] = ~stimMem[k][15:13];
    runSeq(4, 0);
    check(mismatchCnt == 0, "R2", "filler bits no effect", mismatchCnt, 0);
  endtask

  task automatic tCountAndClear();
    setVectors();
    erMem[1][9] = ~erMem[1][9];
    erMem[3][0] = ~erMem[3][0];
    erMem[3][7] = ~erMem[3][7];
    runSeq(4, 0);
    check(mismatchCnt == 3, "R8", "count of failing cycles", mismatchCnt, 3);
    setVectors();
    runSeq(2, 0);
    check(!mismatch && mismatchCnt == 0, "R8", "cleared by new run", mismatchCnt, 0);
  endtask

  task automatic tShortRuns();
    setVectors();
    runSeq(1, 0);
    check(mismatchCnt == 0, "R4", "single pattern run", mismatchCnt, 0);
    runSeq(0, 0);
    check(mismatchCnt == 0, "R4", "empty run", mismatchCnt, 0);
  endtask

  task automatic tBusyStart();
    setVectors();
    runSeq(3, 1);
    check(!busy && mismatchCnt == 0, "R10", "start while busy ignored", busy, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    setVectors();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tClean();
    tFirstMasked();
    tRespFault();
    tBeyondWindow();
    tPoFault();
    tPadIgnored();
    tCountAndClear();
    tShortRuns();
    tBusyStart();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule